// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block is a real-time clock peripheral on an 8-bit port bus. A prescaler divides the system clock down to a 100 kHz timebase, so one tick arrives every 10 µs. Each tick decrements a down counter.

When a tick finds the counter at zero, the counter reloads from a start-count register that the processor writes. The same event sets an interrupt status flag. The interrupt request line is high while that flag is set and the processor has enabled interrupts.

Two offsets are decoded on the bus:

- Offset 0 holds the start count on a write and shows the live count on a read.
- Offset 1 takes the interrupt enable on a write and shows the status flag on a read.

The processor clears the flag either by pulsing the interrupt acknowledge input or by reading offset 1. A start count of S gives one interrupt every S+1 ticks. For example, 199 gives 2 ms, which is 500 Hz.

Top module: `periodic_irq_timer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the count, the start count, the status flag and the enable are all zero, and `irq` and `bus_ack` are low.
- R2: `bus_ack` is high in exactly the cycles in which `bus_cyc` and `bus_stb` are both high. It is combinational and adds no wait state.
- R3: An acknowledged write with `bus_we`=1 and `bus_adr`=0 loads `bus_wdata` into both the start count and the live count at that clock edge. `bus_rdata` shows the live count whenever `bus_adr`=0, whether or not a bus cycle is active.
- R4: A tick occurs once every CLK_HZ/TICK_HZ clock cycles. Each tick that does not coincide with a count write lowers a nonzero count by exactly one, and the count changes at no other time.
- R5: A tick that finds the count at zero reloads it from the start count and sets the status flag. A start count of S therefore sets the flag every (S+1) ticks, and a start count of 0 sets it on every tick.
- R6: An acknowledged write with `bus_adr`=1 sets the interrupt enable from `bus_wdata` bit 0. The other data bits have no effect.
- R7: `irq` is high exactly when the status flag and the enable are both set. The flag sets on expiry whether or not the enable is set.
- R8: With `bus_adr`=1, `bus_rdata` is the status flag in bit 0 with all upper bits zero. An acknowledged read of offset 1 clears the flag at the end of that cycle.
- R9: `irq_ack` held high for one cycle clears the flag. An expiry in the same cycle wins over any clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cyc | input | 1 | Bus cycle valid |
| bus_stb | input | 1 | Bus strobe for this peripheral |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_adr | input | 1 | Register offset (0 count, 1 control/status) |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for the addressed offset |
| bus_ack | output | 1 | Bus acknowledge |
| irq_ack | input | 1 | Interrupt acknowledge from the processor |
| irq | output | 1 | Interrupt request |

## Verification
A wrong prescaler phase or a reload that is off by one shows at `irq` as an interval that misses (S+1)·CLK_HZ/TICK_HZ cycles. It is visible at the second expiry after a count write, one period at most. A faulty decrement shows on `bus_rdata` at offset 0 as a count that is off after a fixed number of ticks from a write. A flag that fails to set or clear shows on the very next cycle, either through `irq` or through a look at offset 1.

// File: rtl/pit_pkg.sv
package pit_pkg;

  // Register offsets decoded on the port bus.
  typedef enum logic {
    OFS_COUNT = 1'b0,
    OFS_CTRL  = 1'b1
  } pit_ofs_e;

  // System clock cycles per timebase tick, rounded, never below one.
  function automatic int tick_divisor(input int clk_hz, input int tick_hz);
    int d;
    d = (clk_hz + tick_hz / 2) / tick_hz;
    return (d < 1) ? 1 : d;
  endfunction

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int DIV = 500
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_pass
      logic unused_inputs;
      assign unused_inputs = clk ^ rst;
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] phase_q;

      assign tick = (phase_q == LAST);

      always_ff @(posedge clk) begin
        if (rst)       phase_q <= '0;
        else if (tick) phase_q <= '0;
        else           phase_q <= phase_q + CW'(1);
      end
    end
  endgenerate

endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count_q,
  output logic [W-1:0] start_q,
  output logic         expire
);

  // Next count for one clock edge without a load.
  function automatic logic [W-1:0] count_step(input logic [W-1:0] cur,
                                               input logic [W-1:0] st,
                                               input logic         tk);
    if (!tk)           return cur;
    else if (cur == '0) return st;
    else               return cur - W'(1);
  endfunction

  assign expire = tick && !load && (count_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      start_q <= '0;
    end else if (load) begin
      count_q <= load_val;
      start_q <= load_val;
    end else begin
      count_q <= count_step(count_q, start_q, tick);
    end
  end

endmodule

// File: rtl/pit_regs.sv
module pit_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_cyc,
  input  logic         bus_stb,
  input  logic         bus_we,
  input  logic         bus_adr,
  input  logic         en_bit,
  input  logic [W-1:0] count_q,
  input  logic         expire,
  input  logic         irq_ack,
  output logic         bus_ack,
  output logic [W-1:0] bus_rdata,
  output logic         wr_cnt,
  output logic         wr_ctl,
  output logic         rd_stat,
  output logic         status_q,
  output logic         enable_q,
  output logic         irq
);
  import pit_pkg::*;

  logic     sel;
  pit_ofs_e ofs;

  assign ofs     = pit_ofs_e'(bus_adr);
  assign sel     = bus_cyc && bus_stb;
  assign bus_ack = sel;
  assign wr_cnt  = sel && bus_we && (ofs == OFS_COUNT);
  assign wr_ctl  = sel && bus_we && (ofs == OFS_CTRL);
  assign rd_stat = sel && !bus_we && (ofs == OFS_CTRL);

  assign bus_rdata = (ofs == OFS_CTRL) ? {{(W-1){1'b0}}, status_q} : count_q;
  assign irq       = status_q && enable_q;

  // Expiry wins over any clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)                       status_q <= 1'b0;
    else if (expire)               status_q <= 1'b1;
    else if (rd_stat || irq_ack)   status_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)         enable_q <= 1'b0;
    else if (wr_ctl) enable_q <= en_bit;
  end

endmodule

// File: rtl/periodic_irq_timer.sv
module periodic_irq_timer #(
  parameter int W       = 8,
  parameter int CLK_HZ  = 50_000_000,
  parameter int TICK_HZ = 100_000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_cyc,
  input  logic         bus_stb,
  input  logic         bus_we,
  input  logic         bus_adr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         bus_ack,
  input  logic         irq_ack,
  output logic         irq
);

  localparam int DIV = pit_pkg::tick_divisor(CLK_HZ, TICK_HZ);

  // Internal events, named for the checker.
  logic         tick;
  logic         wr_cnt;
  logic         wr_ctl;
  logic         rd_stat;
  logic         expire;
  logic [W-1:0] count_q;
  logic [W-1:0] start_q;
  logic         status_q;
  logic         enable_q;

  pit_prescaler #(.DIV(DIV)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  pit_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .load     (wr_cnt),
    .load_val (bus_wdata),
    .count_q  (count_q),
    .start_q  (start_q),
    .expire   (expire)
  );

  pit_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_cyc   (bus_cyc),
    .bus_stb   (bus_stb),
    .bus_we    (bus_we),
    .bus_adr   (bus_adr),
    .en_bit    (bus_wdata[0]),
    .count_q   (count_q),
    .expire    (expire),
    .irq_ack   (irq_ack),
    .bus_ack   (bus_ack),
    .bus_rdata (bus_rdata),
    .wr_cnt    (wr_cnt),
    .wr_ctl    (wr_ctl),
    .rd_stat   (rd_stat),
    .status_q  (status_q),
    .enable_q  (enable_q),
    .irq       (irq)
  );

endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         bus_cyc,
  input logic         bus_stb,
  input logic         bus_ack,
  input logic [W-1:0] bus_wdata,
  input logic         irq,
  input logic         irq_ack,
  input logic         tick,
  input logic         wr_cnt,
  input logic         wr_ctl,
  input logic         rd_stat,
  input logic         expire,
  input logic [W-1:0] count_q,
  input logic [W-1:0] start_q,
  input logic         status_q,
  input logic         enable_q
);

  p_ack_r2: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> (bus_cyc && bus_stb));

  p_noack_r2: assert property (@(posedge clk) disable iff (rst)
    !(bus_cyc && bus_stb) |-> !bus_ack);

  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> (count_q == $past(bus_wdata)) && (start_q == $past(bus_wdata)));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_cnt) |=> $stable(count_q));

  p_dec_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_cnt && count_q != '0) |=> (count_q == $past(count_q) - W'(1)));

  p_reload_r5: assert property (@(posedge clk) disable iff (rst)
    expire |=> (count_q == $past(start_q)) && status_q);

  p_en_r6: assert property (@(posedge clk) disable iff (rst)
    wr_ctl |=> (enable_q == $past(bus_wdata[0])));

  p_irq_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> (enable_q && status_q));

  p_rdclr_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !expire) |=> !status_q);

  p_ackclr_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !expire) |=> !status_q);

endmodule

bind periodic_irq_timer pit_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_cyc   (bus_cyc),
  .bus_stb   (bus_stb),
  .bus_ack   (bus_ack),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .irq_ack   (irq_ack),
  .tick      (tick),
  .wr_cnt    (wr_cnt),
  .wr_ctl    (wr_ctl),
  .rd_stat   (rd_stat),
  .expire    (expire),
  .count_q   (count_q),
  .start_q   (start_q),
  .status_q  (status_q),
  .enable_q  (enable_q)
);

// File: tb/sim_periodic_irq_timer.sv
module sim_periodic_irq_timer;

  localparam int W       = 8;
  localparam int CLK_HZ  = 500_000;
  localparam int TICK_HZ = 100_000;
  localparam int DIV     = CLK_HZ / TICK_HZ;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cyc = 1'b0, stb = 1'b0, we = 1'b0, adr = 1'b0, iack = 1'b0;
  logic [W-1:0] wd = '0;
  wire  [W-1:0] rd;
  wire          ack, irq;

  int     n_chk = 0, n_fail = 0;
  longint cyc_cnt = 0;
  bit     done = 1'b0;
  logic   last_ack;

  periodic_irq_timer #(.W(W), .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u0 (
    .clk(clk), .rst(rst), .bus_cyc(cyc), .bus_stb(stb), .bus_we(we),
    .bus_adr(adr), .bus_wdata(wd), .bus_rdata(rd), .bus_ack(ack),
    .irq_ack(iack), .irq(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [W-1:0] d);
    @(negedge clk);
    cyc = 1; stb = 1; we = 1; adr = a; wd = d;
    #1 last_ack = ack;
    @(negedge clk);
    cyc = 0; stb = 0; we = 0;
    #1;
  endtask

  task automatic bus_read(input logic a, output logic [W-1:0] d);
    @(negedge clk);
    cyc = 1; stb = 1; we = 0; adr = a;
    #1 d = rd; last_ack = ack;
    @(negedge clk);
    cyc = 0; stb = 0;
    #1;
  endtask

  task automatic pulse_ack();
    @(negedge clk); iack = 1;
    @(negedge clk); iack = 0;
    #1;
  endtask

  task automatic wait_irq(output longint t);
    t = -1;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk); #1;
      if (irq) begin t = cyc_cnt; break; end
    end
    if (t < 0) check("R5 irq timeout", 0, 1);
  endtask

  task automatic measure(input int s);
    longint t0, t1;
    adr = 0;
    bus_write(1'b0, W'(s));
    check("R2 write ack", last_ack, 1);
    check("R3 count after write", rd, s);
    pulse_ack();
    wait_irq(t0);
    iack = 1; @(negedge clk); iack = 0; #1;
    check("R9 irq_ack clears", irq, 0);
    wait_irq(t1);
    check($sformatf("R5 period S=%0d", s), t1 - t0, (s + 1) * DIV);
    iack = 1; @(negedge clk); iack = 0; #1;
  endtask

  always @(posedge clk) begin
    if (!done && cyc_cnt > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc_cnt);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    check("R1 count in reset", rd, 0);
    check("R1 irq in reset", irq, 0);
    rst = 0;
    #1;
    check("R1 count after reset", rd, 0);
    adr = 1; #1;
    check("R1 status after reset", rd, 0);
    check("R1 ack after reset", ack, 0);
    check("R1 irq after reset", irq, 0);

    // R2: ack needs both cyc and stb
    cyc = 1; #1 check("R2 cyc only", ack, 0);
    cyc = 0; stb = 1; #1 check("R2 stb only", ack, 0);
    cyc = 1; #1 check("R2 cyc and stb", ack, 1);
    cyc = 0; stb = 0; #1;

    // R6: enable on
    bus_write(1'b1, 8'h01);

    // R5 sweep of start counts
    for (int i = 0; i < 19; i++) begin
      int sv;
      sv = (i < 16) ? i : (i == 16 ? 64 : (i == 17 ? 128 : 255));
      measure(sv);
    end

    // R4: exactly ten ticks over ten divisor periods after a load
    adr = 0;
    bus_write(1'b0, 8'd100);
    check("R3 load 100", rd, 100);
    repeat (10 * DIV) @(negedge clk);
    #1 check("R4 count after 10 ticks", rd, 90);

    // R7: status sets with enable off, irq stays low
    bus_write(1'b1, 8'h00);
    bus_write(1'b0, 8'd255);
    pulse_ack();
    adr = 1;
    v = '0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk); #1;
      if (rd[0]) begin v = rd; break; end
    end
    check("R7 status set with enable off", v, 1);
    check("R7 irq low while disabled", irq, 0);
    bus_write(1'b1, 8'h01);
    check("R7 irq after enable", irq, 1);
    bus_write(1'b1, 8'hFE);
    check("R6 upper bits ignored, bit0 clears enable", irq, 0);

    // R8: acknowledged status read returns the flag and clears it
    bus_read(1'b1, v);
    check("R8 status read value", v, 1);
    check("R8 read ack", last_ack, 1);
    check("R8 status after read", rd, 0);
    bus_write(1'b1, 8'h01);
    check("R8 irq stays low after clear", irq, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule